// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models the target side of a three-wire serial EEPROM with a small word array. A host raises the chip select and clocks in a frame on the serial input. Each frame is a start bit, a two-bit opcode, an address and, for the two write commands, a data word. The block decodes the frame and then reads a word out on the serial output, programs or erases one word, fills the whole array with a pattern or with ones, or sets or clears a write-protect latch. All pins are sampled by the system clock, and a rising edge on the serial clock is found from the sampled values.

Programming is self-timed. It begins when chip select falls after a complete frame and lasts a set number of system clocks. While chip select is high after that, the serial output reports busy or ready. A strap input picks byte-wide or 16-bit word organisation, and the address and data field widths follow from it. The programming time is a parameter, and so is the address width.

Top module: `serial_eeprom_target`

## Requirements
- R1: With chip select high, a frame starts at the first serial-clock rise that samples a 1 on the serial input. Rises that sample 0 before that are ignored. The next two bits are the opcode: 10 read, 01 write, 11 erase, 00 extended.
- R2: When `word16`=0, the address is 7 bits and the data is 8 bits. When `word16`=1, the address is 6 bits and the data is 16 bits. All fields are sent MSB-first. Byte address 2w+1 is the upper half of word w, and byte address 2w is the lower half.
- R3: On a read, the rise that takes the last address bit puts a 0 on `ser_out` with `ser_out_en`=1. Each later rise presents the next data bit, MSB-first. After the last data bit, `ser_out` is 0.
- R4: After reset, writing is disabled. In the extended group, the top two address bits select the command: 11 enables writing and 00 disables it. While writing is disabled, write, erase, erase-all and write-all change nothing and start no programming cycle.
- R5: A programming cycle starts on the fall of chip select after a complete frame, and it lasts PROG_CYCLES system clocks.
- R6: Once programming has started, whenever chip select is high and no read is in progress, `ser_out_en`=1 and `ser_out` shows 0 while busy and 1 when ready.
- R7: A serial-clock rise that samples chip select high and serial input high clears the status indication, and `ser_out_en` returns to 0.
- R8: Erase (opcode 11) sets the addressed word to all ones. Extended selector 10 sets the whole array to all ones.
- R9: Extended selector 01 writes the supplied data to every word. In byte organisation it writes to every byte.
- R10: If more data bits than the word width are sent, the last 8 or 16 bits received are used.
- R11: If chip select falls before the whole frame and its data have been received, the array does not change and no programming cycle starts.
- R12: While programming is busy, frames are not decoded, so a command sent in that time has no effect.
- R13: While chip select is low, and after reset, `ser_out` and `ser_out_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word16 | input | 1 | Organisation strap: 1 selects 16-bit words, 0 selects bytes |
| chip_sel | input | 1 | Active-high chip select |
| ser_clk | input | 1 | Serial clock, sampled by `clk` |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output: read data or ready/busy status |
| ser_out_en | output | 1 | High while `ser_out` is driven |

## Verification
A reference array in the bench follows every command, and each read-back is compared bit by bit, including the dummy 0 and the trailing 0. The bench sends a 20-bit data field to check that only the last 16 bits are kept. A design that kept the first bits would read back a shifted word. It also reads the same word in both organisations: a design with the byte halves swapped fails the byte reads. Further cases try programming while write-protected, drop chip select in the middle of the data field, and send a write-disable while busy. A design that honoured any of these would either show a status indication or lose the later write. The status output is sampled inside the busy window and after it, and once more after a start bit. This catches a wrong cycle count and a clear that does not happen.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADR, ST_DATA, ST_READ, ST_DONE
  } fe_state_t;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;
  localparam logic [1:0] OPC_EXT   = 2'b00;

  localparam logic [1:0] EXT_UNLOCK = 2'b11;
  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_CLRALL = 2'b10;
  localparam logic [1:0] EXT_FILL   = 2'b01;
endpackage

// File: rtl/ee_word_store.sv
module ee_word_store #(
  parameter int WORDS  = 64,
  parameter int WORD_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [WORD_W/LANE_W-1:0] lane_en,
  input  logic [$clog2(WORDS)-1:0] wa,
  input  logic [WORD_W-1:0]        wd,
  input  logic [$clog2(WORDS)-1:0] ra,
  output logic [WORD_W-1:0]        rd
);
  localparam int LANES = WORD_W / LANE_W;

  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && lane_en[l]) mem[wa][l*LANE_W +: LANE_W] <= wd[l*LANE_W +: LANE_W];
    end
    rd <= mem[ra];
  end
endmodule

// File: rtl/ee_prog_engine.sv
module ee_prog_engine #(
  parameter int WORDS       = 64,
  parameter int PROG_CYCLES = 80
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     all_in,
  input  logic [$clog2(WORDS)-1:0] addr_in,
  input  logic [1:0]               lane_in,
  input  logic [15:0]              data_in,
  output logic                     busy,
  output logic                     we,
  output logic [$clog2(WORDS)-1:0] wa,
  output logic [1:0]               wlane,
  output logic [15:0]              wd
);
  localparam int WAW = $clog2(WORDS);
  localparam int RUN = (PROG_CYCLES > WORDS) ? PROG_CYCLES : WORDS + 1;
  localparam int TW  = $clog2(RUN + 1);

  logic [TW-1:0]    tmr;
  logic [TW-1:0]    run_len;
  logic [WAW:0]     idx;
  logic             all_q, one_q;
  logic [WAW-1:0]   sa;
  logic [1:0]       slane;
  logic [15:0]      sd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; tmr <= '0; run_len <= '0; idx <= '0;
      all_q <= 1'b0; one_q <= 1'b0; sa <= '0; slane <= '0; sd <= '0;
    end else if (start) begin
      busy <= 1'b1; tmr <= TW'(RUN - 1); run_len <= '0; idx <= '0;
      all_q <= all_in; one_q <= !all_in;
      sa <= addr_in; slane <= lane_in; sd <= data_in;
    end else if (busy) begin
      run_len <= run_len + 1'b1;
      one_q <= 1'b0;
      if (all_q && idx != (WAW+1)'(WORDS)) idx <= idx + 1'b1;
      if (tmr == '0) busy <= 1'b0;
      else tmr <= tmr - 1'b1;
    end
  end

  always_comb begin
    we    = busy && (all_q ? (idx != (WAW+1)'(WORDS)) : one_q);
    wa    = all_q ? idx[WAW-1:0] : sa;
    wlane = all_q ? 2'b11 : slane;
    wd    = sd;
  end

  // R12
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_len == TW'(RUN));
  // R9
  walk_all_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && all_q) |-> idx == (WAW+1)'(WORDS));
endmodule

// File: rtl/ee_cmd_frontend.sv
module ee_cmd_frontend
  import eeprom_pkg::*;
#(
  parameter int A8 = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_q,
  input  logic              di_q,
  input  logic              sk_rise,
  input  logic              cs_fall,
  input  logic              word16,
  input  logic              busy,
  input  logic [WORD_W-1:0] rd_word,
  output logic [A8-2:0]     word_addr,
  output logic [1:0]        lane_sel,
  output logic              prog_start,
  output logic              prog_all,
  output logic [WORD_W-1:0] prog_data,
  output logic              rd_active,
  output logic              rd_bit,
  output logic              stat_armed,
  output logic              wr_enabled
);
  localparam int CW = $clog2(WORD_W + 1);

  fe_state_t         st;
  logic [1:0]        opc;
  logic [A8-1:0]     adr;
  logic [WORD_W-1:0] dsh;
  logic [WORD_W:0]   rsh;
  logic [CW-1:0]     cnt;
  logic [1:0]        ld_cnt;
  logic              all_q, ones_q, pend_q;
  logic [CW-1:0]     aw_last, dw_len;
  logic [A8-1:0]     adr_nx;
  logic [1:0]        ext_sel;
  logic              complete;

  always_comb begin
    aw_last   = word16 ? CW'(A8 - 2) : CW'(A8 - 1);
    dw_len    = word16 ? CW'(WORD_W) : CW'(BYTE_W);
    adr_nx    = {adr[A8-2:0], di_q};
    ext_sel   = word16 ? adr_nx[A8-2 -: 2] : adr_nx[A8-1 -: 2];
    complete  = (st == ST_DONE && pend_q) || (st == ST_DATA && cnt == dw_len);
    word_addr = word16 ? adr[A8-2:0] : adr[A8-1:1];
    lane_sel  = word16 ? 2'b11 : (adr[0] ? 2'b10 : 2'b01);
    rd_active = (st == ST_READ);
    rd_bit    = rsh[WORD_W];
  end

  always_ff @(posedge clk) begin
    prog_start <= 1'b0;
    if (rst) begin
      st <= ST_IDLE; opc <= '0; adr <= '0; dsh <= '0; rsh <= '0; cnt <= '0;
      ld_cnt <= '0; all_q <= 1'b0; ones_q <= 1'b0; pend_q <= 1'b0;
      wr_enabled <= 1'b0; stat_armed <= 1'b0; prog_all <= 1'b0; prog_data <= '0;
    end else begin
      if (sk_rise && cs_q && di_q) stat_armed <= 1'b0;
      if (!cs_q) begin
        st <= ST_IDLE;
        ld_cnt <= '0;
        if (cs_fall && complete && wr_enabled && !busy) begin
          prog_start <= 1'b1;
          prog_all   <= all_q;
          prog_data  <= ones_q ? '1 : (word16 ? dsh : {dsh[BYTE_W-1:0], dsh[BYTE_W-1:0]});
          stat_armed <= 1'b1;
        end
      end else begin
        if (ld_cnt == 2'd2) ld_cnt <= 2'd1;
        else if (ld_cnt == 2'd1) begin
          ld_cnt <= 2'd0;
          rsh[WORD_W-1:0] <= word16 ? rd_word
                           : {(adr[0] ? rd_word[15:8] : rd_word[7:0]), 8'h00};
        end
        if (sk_rise && !busy) begin
          unique case (st)
            ST_IDLE: if (di_q) begin
              st <= ST_OPC; cnt <= '0; adr <= '0;
              pend_q <= 1'b0; all_q <= 1'b0; ones_q <= 1'b0;
            end
            ST_OPC: begin
              opc <= {opc[0], di_q};
              if (cnt == CW'(1)) begin st <= ST_ADR; cnt <= '0; end
              else cnt <= cnt + 1'b1;
            end
            ST_ADR: begin
              adr <= adr_nx;
              if (cnt == aw_last) begin
                cnt <= '0;
                unique case (opc)
                  OPC_READ:  begin st <= ST_READ; rsh <= '0; ld_cnt <= 2'd2; end
                  OPC_WRITE: begin st <= ST_DATA; dsh <= '0; pend_q <= 1'b1; end
                  OPC_ERASE: begin st <= ST_DONE; pend_q <= 1'b1; ones_q <= 1'b1; end
                  default: begin
                    unique case (ext_sel)
                      EXT_UNLOCK: begin wr_enabled <= 1'b1; st <= ST_DONE; end
                      EXT_LOCK:   begin wr_enabled <= 1'b0; st <= ST_DONE; end
                      EXT_CLRALL: begin
                        st <= ST_DONE; pend_q <= 1'b1; all_q <= 1'b1; ones_q <= 1'b1;
                      end
                      default: begin
                        st <= ST_DATA; dsh <= '0; pend_q <= 1'b1; all_q <= 1'b1;
                      end
                    endcase
                  end
                endcase
              end else cnt <= cnt + 1'b1;
            end
            ST_DATA: begin
              dsh <= {dsh[WORD_W-2:0], di_q};
              if (cnt != dw_len) cnt <= cnt + 1'b1;
            end
            ST_READ: rsh <= {rsh[WORD_W-1:0], 1'b0};
            default: ;
          endcase
        end
      end
    end
  end

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && $past(st) == ST_IDLE) |-> st == ST_IDLE);
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_start) |-> !cs_q);
endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target #(
  parameter int ADDR_BITS_X8 = 7,
  parameter int PROG_CYCLES  = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic word16,
  input  logic chip_sel,
  input  logic ser_clk,
  input  logic ser_in,
  output logic ser_out,
  output logic ser_out_en
);
  import eeprom_pkg::*;
  localparam int WORDS = 2 ** (ADDR_BITS_X8 - 1);
  localparam int WAW   = ADDR_BITS_X8 - 1;

  logic cs_q, cs_d, sk_q, sk_d, di_q;
  logic sk_rise, cs_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b0; cs_d <= 1'b0; sk_q <= 1'b0; sk_d <= 1'b0; di_q <= 1'b0;
    end else begin
      cs_q <= chip_sel; cs_d <= cs_q;
      sk_q <= ser_clk;  sk_d <= sk_q;
      di_q <= ser_in;
    end
  end
  assign sk_rise = sk_q & ~sk_d;
  assign cs_fall = cs_d & ~cs_q;

  logic [WAW-1:0]    fe_addr, eng_wa;
  logic [1:0]        fe_lane, eng_lane;
  logic              fe_start, fe_all, fe_rd, fe_bit, fe_stat, fe_wen;
  logic [WORD_W-1:0] fe_data, rd_word, eng_wd;
  logic              busy, eng_we;

  ee_cmd_frontend #(.A8(ADDR_BITS_X8)) i_front (
    .clk(clk), .rst(rst), .cs_q(cs_q), .di_q(di_q), .sk_rise(sk_rise),
    .cs_fall(cs_fall), .word16(word16), .busy(busy), .rd_word(rd_word),
    .word_addr(fe_addr), .lane_sel(fe_lane), .prog_start(fe_start),
    .prog_all(fe_all), .prog_data(fe_data), .rd_active(fe_rd), .rd_bit(fe_bit),
    .stat_armed(fe_stat), .wr_enabled(fe_wen)
  );

  ee_prog_engine #(.WORDS(WORDS), .PROG_CYCLES(PROG_CYCLES)) i_engine (
    .clk(clk), .rst(rst), .start(fe_start), .all_in(fe_all), .addr_in(fe_addr),
    .lane_in(fe_lane), .data_in(fe_data), .busy(busy), .we(eng_we),
    .wa(eng_wa), .wlane(eng_lane), .wd(eng_wd)
  );

  ee_word_store #(.WORDS(WORDS), .WORD_W(WORD_W), .LANE_W(BYTE_W)) i_store (
    .clk(clk), .we(eng_we), .lane_en(eng_lane), .wa(eng_wa), .wd(eng_wd),
    .ra(fe_addr), .rd(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst || !cs_q) begin
      ser_out <= 1'b0; ser_out_en <= 1'b0;
    end else if (fe_rd) begin
      ser_out <= fe_bit; ser_out_en <= 1'b1;
    end else if (fe_stat) begin
      ser_out <= !busy; ser_out_en <= 1'b1;
    end else begin
      ser_out <= 1'b0; ser_out_en <= 1'b0;
    end
  end

  // R4
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> fe_wen);
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!chip_sel && $past(!chip_sel) && $past(!chip_sel, 2) && $past(!chip_sel, 3))
      |-> (!ser_out_en && !ser_out));
endmodule

// File: tb/test_serial_eeprom_target.sv
module test_serial_eeprom_target;
  localparam int CLK_NS = 10;
  localparam int PROG   = 150;

  logic clk = 1'b0, rst = 1'b1, word16 = 1'b0, chip_sel = 1'b0, ser_clk = 1'b0, ser_in = 1'b0;
  logic ser_out, ser_out_en;
  int checks = 0, errors = 0;
  logic [7:0] m8 [128];
  bit wen_m = 0;

  serial_eeprom_target #(.ADDR_BITS_X8(7), .PROG_CYCLES(PROG)) i_serial_eeprom_target (
    .clk(clk), .rst(rst), .word16(word16), .chip_sel(chip_sel), .ser_clk(ser_clk),
    .ser_in(ser_in), .ser_out(ser_out), .ser_out_en(ser_out_en)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    ser_in = b; tick(1); ser_clk = 1'b1; tick(3); ser_clk = 1'b0; tick(3);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask

  task automatic cs_on;  chip_sel = 1'b1; tick(3); endtask
  task automatic cs_off; chip_sel = 1'b0; ser_in = 1'b0; tick(3); endtask

  function automatic int aw(input bit o); return o ? 6 : 7; endfunction
  function automatic int dw(input bit o); return o ? 16 : 8; endfunction

  function automatic logic [15:0] word_of(input bit o, input int a);
    return o ? {m8[2*a+1], m8[2*a]} : {8'h00, m8[a]};
  endfunction

  task automatic put(input bit o, input int a, input logic [15:0] d);
    if (o) begin m8[2*a+1] = d[15:8]; m8[2*a] = d[7:0]; end
    else m8[a] = d[7:0];
  endtask

  task automatic frame(input bit o, input logic [1:0] op, input int a,
                       input logic [31:0] d, input int nd);
    word16 = o;
    cs_on; sk_bit(1'b1); send(op, 2); send(a, aw(o)); if (nd > 0) send(d, nd); cs_off;
  endtask

  task automatic ext(input bit o, input logic [1:0] sel, input logic [31:0] d, input int nd);
    frame(o, 2'b00, int'(sel) << (aw(o) - 2), d, nd);
    if (sel == 2'b11) wen_m = 1;
    else if (sel == 2'b00) wen_m = 0;
    else if (wen_m) begin
      for (int i = 0; i < 128; i++) m8[i] = (sel == 2'b10) ? 8'hFF : (o ? (i[0] ? d[15:8] : d[7:0]) : d[7:0]);
    end
    tick(PROG + 10);
  endtask

  task automatic wr(input bit o, input int a, input logic [31:0] d, input int nd);
    frame(o, 2'b01, a, d, nd);
    if (wen_m && nd >= dw(o)) put(o, a, d[15:0]);
    tick(PROG + 10);
  endtask

  task automatic rd(input bit o, input int a, input int lead, input string req);
    logic [15:0] e;
    e = word_of(o, a);
    word16 = o;
    cs_on;
    for (int i = 0; i < lead; i++) sk_bit(1'b0);
    sk_bit(1'b1); send(2'b10, 2); send(a, aw(o));
    chk({req, " R3 dummy"}, {ser_out_en, ser_out}, 2'b10);
    for (int i = dw(o) - 1; i >= 0; i--) begin
      sk_bit(1'b0);
      chk({req, " R3 data"}, ser_out, e[i]);
    end
    sk_bit(1'b0);
    chk("R3 tail", ser_out, 1'b0);
    cs_off;
    chk("R13 cs low", {ser_out_en, ser_out}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R5 actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(6); rst = 1'b0; tick(2);
    chk("R13 reset", {ser_out_en, ser_out}, 2'b00);

    // R4: erase-all while locked starts nothing
    ext(0, 2'b10, 0, 0);
    cs_on; chk("R4 locked no status", ser_out_en, 1'b0); cs_off;

    ext(0, 2'b11, 0, 0);
    ext(0, 2'b10, 0, 0);
    rd(0, 0, 0, "R8 eral a0");
    rd(0, 127, 2, "R1 leading zeros / R8 a127");

    // R4: write after lock does nothing
    ext(0, 2'b00, 0, 0);
    wr(0, 3, 32'h5A, 8);
    cs_on; chk("R4 locked write no status", ser_out_en, 1'b0); cs_off;
    rd(0, 3, 0, "R4 unchanged");

    // R5 R6 R7: status during programming
    ext(0, 2'b11, 0, 0);
    frame(0, 2'b01, 3, 32'h5A, 8);
    put(0, 3, 16'h005A);
    cs_on;
    chk("R6 busy", {ser_out_en, ser_out}, 2'b10);
    tick(PROG - 15);
    chk("R5 still busy", {ser_out_en, ser_out}, 2'b10);
    tick(20);
    chk("R5 R6 ready", {ser_out_en, ser_out}, 2'b11);
    sk_bit(1'b1);
    chk("R7 cleared", ser_out_en, 1'b0);
    cs_off;
    rd(0, 3, 0, "R4 enabled write");
    rd(0, 2, 0, "R2 neighbour");

    // R10 R2: overlong 16-bit write, read in both organisations
    wr(1, 5, 32'hA1234, 20);
    rd(1, 5, 0, "R10 last bits");
    rd(0, 10, 0, "R2 low byte");
    rd(0, 11, 0, "R2 high byte");
    wr(0, 12, 32'h7C3, 12);
    rd(0, 12, 0, "R10 byte overlong");

    // R8 erase single words
    frame(1, 2'b11, 5, 0, 0); put(1, 5, 16'hFFFF); tick(PROG + 10);
    rd(1, 5, 0, "R8 erase word");
    frame(0, 2'b11, 3, 0, 0); put(0, 3, 16'h00FF); tick(PROG + 10);
    rd(0, 3, 0, "R8 erase byte");

    // R9 write-all
    ext(0, 2'b01, 32'hA5, 8);
    rd(0, 77, 0, "R9 fill byte");
    rd(1, 9, 0, "R9 fill word");

    // R11 abort mid-data
    word16 = 0;
    cs_on; sk_bit(1'b1); send(2'b01, 2); send(20, 7); send(4'hC, 4); cs_off;
    cs_on; chk("R11 no status", ser_out_en, 1'b0); cs_off;
    tick(PROG + 10);
    rd(0, 20, 0, "R11 unchanged");

    // R12 lock command during busy is ignored
    frame(0, 2'b01, 30, 32'h11, 8); put(0, 30, 16'h0011);
    tick(1);
    frame(0, 2'b00, 0, 0, 0);
    tick(PROG + 10);
    wr(0, 31, 32'h22, 8);
    rd(0, 30, 0, "R12 first write");
    rd(0, 31, 0, "R12 still unlocked");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule